// File: doc/BRIEF.md
# Two-State Fetch and Branch Sequencer

This block is the control core of a small 8-bit processor. It holds the instruction register, the program counter and the register-bank bit, and it alone drives the shared memory address bus. Instructions whose top bit is 0 are ALU operations: the sequencer only fetches the next byte while the ALU works. Instructions whose top bit is 1 take two cycles. The first cycle moves data over the bus or changes the program counter, and the second fetches the next instruction.

The register file and ALU are outside this block. The sequencer names the two registers it wants to read through index outputs, takes their values back, and sends write-back requests out for the link value on a call and for load data. Register indices are 3 bits wide: the top bit is the bank and the low two bits are the offset within the bank. Operand-2 register fields (bits [2:0]) are absolute indices. Operand-1 fields (bits [4:3]) are offsets into the current bank.

Top module: `fetch_seq`

## Requirements
- R1: A synchronous active-low reset sets the program counter to 0, the bank bit to 0 and the instruction register to 0x00, which is an ALU code. In the first cycle after reset the bus shows address 0, with no write strobe and no write-back.
- R2: An instruction with bit 7 = 0 lasts one cycle. The bus shows the program counter and the counter advances by one each cycle. There is no write strobe and no write-back.
- R3: An instruction with bit 7 = 1 lasts two cycles. In its second cycle the bus shows the next fetch address, and there is neither a write strobe nor a write-back.
- R4: 11000rrr jumps unconditionally. The next fetch is from the value of register rrr.
- R5: 11001rrr and 11010rrr jump to register rrr only when bits [4:3] equal {N flag, Z flag}. Otherwise the next fetch is the sequential address.
- R6: 11011rrr (call) toggles the bank bit, jumps to register rrr, and in its first cycle writes the address following the call to offset 0 of the new bank.
- R7: 0x80 (return) jumps to the value of offset 0 of the current bank, and then toggles the bank bit.
- R8: 101ooRRR (store) drives register RRR onto the bus in its first cycle, with the write strobe high and register {bank,oo} as write data. The strobe is high in no other cycle.
- R9: 111ooRRR (load) drives register RRR onto the bus in its first cycle and writes the bus data back to register {bank,oo}.
- R10: Any other code with bit 7 = 1 takes two cycles with no write strobe and no write-back, and fetches the sequential address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 8 | Shared address bus |
| mem_rdata | input | 8 | Instruction or load data from memory |
| mem_wdata | output | 8 | Store data |
| mem_we | output | 1 | Memory write strobe |
| flag_n | input | 1 | Negative condition flag |
| flag_z | input | 1 | Zero condition flag |
| rf_ptr_idx | output | 3 | Index of the register that supplies an address or target |
| rf_ptr_val | input | 8 | Value of that register |
| rf_src_idx | output | 3 | Index of the bank-relative register read for store or return |
| rf_src_val | input | 8 | Value of that register |
| wb_en | output | 1 | Register write-back request |
| wb_idx | output | 3 | Write-back register index |
| wb_data | output | 8 | Write-back value |
| bank | output | 1 | Current register bank |

## Verification
Bus results are combinational in the current state. A store's address and strobe, and a load's write-back, therefore appear in the cycle right after the clock edge that loads the instruction. A jump target appears on the bus one cycle after the first cycle of the jump, and a one-cycle instruction's successor appears one cycle after its own fetch. The bench keeps a cycle index that starts at the release of reset, where the bus shows address 0. It samples every output on the falling edge of the cycle in which the sequence above says the output is due. Results that land in bench-side memory or registers are read after the following edge.

// File: rtl/fseq_pkg.sv
// Shared types for the fetch/branch sequencer.
package fseq_pkg;
    // Sequencer phase: execute (or first cycle) versus second-cycle prefetch.
    typedef enum logic {
        ST_EXEC  = 1'b0,
        ST_FETCH = 1'b1
    } seq_state_e;

    // Instruction class decoded from the instruction register.
    typedef enum logic [2:0] {
        OPC_ALU   = 3'd0,
        OPC_JUMP  = 3'd1,
        OPC_CALL  = 3'd2,
        OPC_RET   = 3'd3,
        OPC_STORE = 3'd4,
        OPC_LOAD  = 3'd5,
        OPC_IDLE2 = 3'd6
    } op_class_e;
endpackage

// File: rtl/fseq_decode.sv
// Instruction classifier.
// Maps an 8-bit instruction to its class and says whether a jump is
// conditional. Assumes the fixed 8-bit instruction layout; purely combinational.
module fseq_decode
    import fseq_pkg::*;
(
    input  logic [7:0] instr,
    output op_class_e  op_class,
    output logic       cond_en
);
    // Classify the instruction by its top bits.
    always_comb begin
        cond_en = 1'b0;
        if (!instr[7]) begin
            op_class = OPC_ALU;
        end else if (instr == 8'h80) begin
            op_class = OPC_RET;
        end else begin
            unique case (instr[6:5])
                2'b01:   op_class = OPC_STORE;
                2'b11:   op_class = OPC_LOAD;
                2'b10: begin
                    if (instr[4:3] == 2'b11) begin
                        op_class = OPC_CALL;
                    end else begin
                        op_class = OPC_JUMP;
                        cond_en  = (instr[4:3] != 2'b00);
                    end
                end
                default: op_class = OPC_IDLE2;
            endcase
        end
    end
endmodule

// File: rtl/fseq_cond.sv
// Jump condition evaluator.
// A conditional jump is taken when the two selector bits equal {N,Z}.
// An unconditional jump is always taken. Combinational.
module fseq_cond (
    input  logic       cond_en,
    input  logic [1:0] sel,
    input  logic       flag_n,
    input  logic       flag_z,
    output logic       take
);
    // Compare the selector bits against the flags.
    always_comb take = !cond_en || (sel == {flag_n, flag_z});
endmodule

// File: rtl/fseq_pcunit.sv
// Program counter and bank bit.
// A load has priority over a step; the bank flips on request. The reset is
// synchronous and active low.
module fseq_pcunit #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          bank_flip,
    output logic [DW-1:0] pc,
    output logic          bank
);
    // Program counter update: jump target or sequential advance.
    always_ff @(posedge clk) begin
        if (!rst_n)    pc <= '0;
        else if (load) pc <= load_val;
        else if (step) pc <= pc + 1'b1;
    end

    // Bank bit update.
    always_ff @(posedge clk) begin
        if (!rst_n)         bank <= 1'b0;
        else if (bank_flip) bank <= ~bank;
    end
endmodule

// File: rtl/fetch_seq.sv
// Two-state fetch and branch sequencer.
// Holds the instruction register and runs one-cycle ALU instructions and
// two-cycle bus/control instructions. Assumes that the register file and
// memory answer combinationally to the indices and address it drives, and
// that they commit writes on the next rising edge.
module fetch_seq
    import fseq_pkg::*;
#(
    parameter int DW = 8,
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic          flag_n,
    input  logic          flag_z,
    output logic [RW-1:0] rf_ptr_idx,
    input  logic [DW-1:0] rf_ptr_val,
    output logic [RW-1:0] rf_src_idx,
    input  logic [DW-1:0] rf_src_val,
    output logic          wb_en,
    output logic [RW-1:0] wb_idx,
    output logic [DW-1:0] wb_data,
    output logic          bank
);
    localparam int OFSW = RW - 1;
    localparam logic [OFSW-1:0] LINK_OFS = '0;

    seq_state_e    state;
    logic [7:0]    ir;
    op_class_e     op_class;
    logic          cond_en;
    logic          take;
    logic          fetch;
    logic          pc_load;
    logic [DW-1:0] pc_val;
    logic          bank_flip;
    logic [DW-1:0] pc;
    logic [OFSW-1:0] opnd1;

    assign opnd1      = ir[3 +: OFSW];
    assign rf_ptr_idx = ir[RW-1:0];

    fseq_decode u_dec (
        .instr    (ir),
        .op_class (op_class),
        .cond_en  (cond_en)
    );

    fseq_cond u_cond (
        .cond_en (cond_en),
        .sel     (ir[4:3]),
        .flag_n  (flag_n),
        .flag_z  (flag_z),
        .take    (take)
    );

    fseq_pcunit #(.DW(DW)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (fetch),
        .load      (pc_load),
        .load_val  (pc_val),
        .bank_flip (bank_flip),
        .pc        (pc),
        .bank      (bank)
    );

    // Bus, register-read and write-back control for the current phase.
    always_comb begin
        mem_addr   = pc;
        mem_we     = 1'b0;
        mem_wdata  = rf_src_val;
        wb_en      = 1'b0;
        wb_idx     = {bank, opnd1};
        wb_data    = mem_rdata;
        rf_src_idx = {bank, opnd1};
        pc_load    = 1'b0;
        pc_val     = rf_ptr_val;
        bank_flip  = 1'b0;
        fetch      = 1'b0;
        if (state == ST_FETCH) begin
            fetch = 1'b1;
        end else begin
            unique case (op_class)
                OPC_ALU:   fetch = 1'b1;
                OPC_JUMP:  pc_load = take;
                OPC_CALL: begin
                    bank_flip = 1'b1;
                    wb_en     = 1'b1;
                    wb_idx    = {~bank, LINK_OFS};
                    wb_data   = pc;
                    pc_load   = 1'b1;
                end
                OPC_RET: begin
                    rf_src_idx = {bank, LINK_OFS};
                    pc_val     = rf_src_val;
                    pc_load    = 1'b1;
                    bank_flip  = 1'b1;
                end
                OPC_STORE: begin
                    mem_addr = rf_ptr_val;
                    mem_we   = 1'b1;
                end
                OPC_LOAD: begin
                    mem_addr = rf_ptr_val;
                    wb_en    = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Phase register: bit-7 instructions spend one extra cycle prefetching.
    always_ff @(posedge clk) begin
        if (!rst_n)                         state <= ST_EXEC;
        else if (state == ST_FETCH)         state <= ST_EXEC;
        else if (op_class != OPC_ALU)       state <= ST_FETCH;
    end

    // Instruction register: captures the byte on the bus at each fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)     ir <= 8'h00;
        else if (fetch) ir <= mem_rdata;
    end
endmodule

// File: rtl/fseq_checker.sv
// Temporal checks on the sequencer, attached through bind.
// Assumes the internal names of fetch_seq.
module fseq_checker
    import fseq_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input seq_state_e    state,
    input logic [7:0]    ir,
    input logic [DW-1:0] pc,
    input logic          bank,
    input logic          mem_we,
    input logic          wb_en,
    input logic [DW-1:0] rf_src_val
);
    // R2: a one-cycle instruction advances the counter by one.
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && !ir[7]) |=> (pc == $past(pc) + 1'b1));

    // R3: a bit-7 instruction is followed by the prefetch phase.
    p_two_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && ir[7]) |=> (state == ST_FETCH));

    // R3: the prefetch phase never writes.
    p_fetch_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |-> (!mem_we && !wb_en));

    // R6: a call flips the bank.
    p_call_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && ir[7:3] == 5'b11011) |=> (bank != $past(bank)));

    // R7: a return loads the saved link value.
    p_ret_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && ir == 8'h80) |=> (pc == $past(rf_src_val)));

    // R8: the write strobe lasts a single cycle.
    p_we_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
endmodule

bind fetch_seq fseq_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .ir         (ir),
    .pc         (pc),
    .bank       (bank),
    .mem_we     (mem_we),
    .wb_en      (wb_en),
    .rf_src_val (rf_src_val)
);

// File: tb/sim_fetch_seq.sv
// Self-checking bench for fetch_seq, with memory and register file modelled here.
module sim_fetch_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr, mem_rdata, mem_wdata;
    logic       mem_we;
    logic       flag_n = 1'b0, flag_z = 1'b0;
    logic [2:0] rf_ptr_idx, rf_src_idx, wb_idx;
    logic [7:0] rf_ptr_val, rf_src_val, wb_data;
    logic       wb_en, bank;

    logic [7:0] mem [256];
    logic [7:0] rf  [8];
    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    assign mem_rdata  = mem[mem_addr];
    assign rf_ptr_val = rf[rf_ptr_idx];
    assign rf_src_val = rf[rf_src_idx];

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            if (wb_en)  rf[wb_idx]    <= wb_data;
        end
    end

    fetch_seq u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .flag_n(flag_n), .flag_z(flag_z),
        .rf_ptr_idx(rf_ptr_idx), .rf_ptr_val(rf_ptr_val), .rf_src_idx(rf_src_idx),
        .rf_src_val(rf_src_val), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .bank(bank)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Enter reset and clear memory and registers.
    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 0; i < 8; i++) rf[i] = 8'h00;
    endtask

    // Leave reset; returns in cycle 0 (bus shows the first fetch).
    task automatic release_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic next_cycle();
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state; R2 exhaustive sweep over all one-cycle codes.
        hold_reset();
        for (int i = 0; i < 128; i++) mem[i] = 8'(i);
        release_reset();
        chk("R1 addr", int'(mem_addr), 0);
        chk("R1 we", int'(mem_we), 0);
        chk("R1 wb", int'(wb_en), 0);
        chk("R1 bank", int'(bank), 0);
        for (int k = 1; k < 128; k++) begin
            next_cycle();
            chk("R2 addr", int'(mem_addr), k);
            chk("R2 quiet", int'(mem_we | wb_en), 0);
        end

        // R4/R5 jumps against every flag pair.
        for (int sel = 0; sel < 3; sel++) begin
            for (int f = 0; f < 4; f++) begin
                int taken;
                hold_reset();
                mem[0] = 8'hC0 | 8'(sel << 3) | 8'h5;
                rf[5] = 8'h40;
                flag_n = f[1];
                flag_z = f[0];
                release_reset();
                taken = (sel == 0) || (sel == f);
                next_cycle();
                chk("R3 first quiet", int'(mem_we | wb_en), 0);
                next_cycle();
                chk(sel == 0 ? "R4 target" : "R5 target", int'(mem_addr), taken ? 8'h40 : 1);
                chk("R3 fetch quiet", int'(mem_we | wb_en), 0);
                next_cycle();
                chk("R5 after", int'(mem_addr), taken ? 8'h41 : 2);
            end
        end
        flag_n = 1'b0;
        flag_z = 1'b0;

        // R6/R7 call then return.
        hold_reset();
        mem[0] = 8'hDE;
        rf[6] = 8'h20;
        mem[8'h20] = 8'h80;
        release_reset();
        next_cycle();
        chk("R6 wb_en", int'(wb_en), 1);
        chk("R6 wb_idx", int'(wb_idx), 4);
        chk("R6 link", int'(wb_data), 1);
        next_cycle();
        chk("R6 target", int'(mem_addr), 8'h20);
        chk("R6 bank", int'(bank), 1);
        next_cycle();
        chk("R7 src idx", int'(rf_src_idx), 4);
        next_cycle();
        chk("R7 target", int'(mem_addr), 1);
        chk("R7 bank", int'(bank), 0);

        // R8 store from bank 0.
        hold_reset();
        mem[0] = 8'hB7;
        rf[7] = 8'h90;
        rf[2] = 8'h5A;
        release_reset();
        next_cycle();
        chk("R8 addr", int'(mem_addr), 8'h90);
        chk("R8 we", int'(mem_we), 1);
        chk("R8 data", int'(mem_wdata), 8'h5A);
        next_cycle();
        chk("R8 we low", int'(mem_we), 0);
        chk("R8 next", int'(mem_addr), 1);
        chk("R8 stored", int'(mem[8'h90]), 8'h5A);

        // R9 load into bank 0.
        hold_reset();
        mem[0] = 8'hFD;
        rf[5] = 8'h70;
        mem[8'h70] = 8'hC3;
        release_reset();
        next_cycle();
        chk("R9 addr", int'(mem_addr), 8'h70);
        chk("R9 wb_idx", int'(wb_idx), 3);
        chk("R9 wb_data", int'(wb_data), 8'hC3);
        next_cycle();
        chk("R9 loaded", int'(rf[3]), 8'hC3);
        chk("R9 next", int'(mem_addr), 1);

        // R9 load inside bank 1 after a call.
        hold_reset();
        mem[0] = 8'hDE;
        rf[6] = 8'h30;
        mem[8'h30] = 8'hED;
        rf[5] = 8'h70;
        mem[8'h70] = 8'h66;
        release_reset();
        next_cycle();
        next_cycle();
        next_cycle();
        chk("R9 bank1 addr", int'(mem_addr), 8'h70);
        chk("R9 bank1 idx", int'(wb_idx), 5);
        next_cycle();
        chk("R9 bank1 value", int'(rf[5]), 8'h66);

        // R10 remaining two-cycle codes do nothing.
        for (int c = 8'h81; c < 8'hA0; c++) begin
            hold_reset();
            mem[0] = 8'(c);
            release_reset();
            next_cycle();
            chk("R10 first", int'(mem_we | wb_en), 0);
            next_cycle();
            chk("R10 second", int'(mem_we | wb_en), 0);
            chk("R10 addr", int'(mem_addr), 1);
            next_cycle();
            chk("R10 step", int'(mem_addr), 2);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule